// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block is the timekeeping core of a real-time clock. It advances on a one-pulse-per-second tick and keeps seven packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year for the 2000 to 2099 century. A single tick can ripple a carry through every field in the same cycle. For example, 23:59:59 on 31 December 2099 rolls to 00:00:00 on 1 January 2000.

The hour byte has two formats. When bit 6 is clear it holds a 24-hour value. When bit 6 is set it holds a 12-hour value with an AM/PM flag in bit 5. A host writes any field through a simple parallel register port, and the written byte takes effect in the next cycle. A control byte holds an active-low run bit that stops counting while it is set. The tick prescaler, the crystal oscillator and the serial front end sit outside this block.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x00 (24-hour midnight), day of week 0x01, day of month 0x01, month 0x01, year 0x00 and control 0x80 (counting stopped).
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. From 0x59 they return to 0x00 and pass a carry to the next field.
- R3: With hour bit 6 clear, hours count in BCD from 0x00 to 0x23. The step from 0x23 to 0x00 carries into the date fields.
- R4: With hour bit 6 set, bits 4..0 hold the BCD hour in the order 12, 01, 02 … 11 and bit 5 is the PM flag. Bit 5 flips on the step from 11 to 12. The date carries only on the step from 11 PM to 12 AM.
- R5: Day of week counts 0x01 to 0x07 and returns to 0x01 on each date carry.
- R6: Day of month returns to 0x01 and carries into the month after its last day. The last day is 0x31 for months 01, 03, 05, 07, 08, 10 and 12, and 0x30 for months 04, 06, 09 and 11. For month 02 it is 0x29 when the year's numeric value is divisible by 4 and 0x28 otherwise.
- R7: Month counts 0x01 to 0x12 and returns to 0x01 with a carry into the year. The year counts 0x00 to 0x99 and returns to 0x00.
- R8: While control bit 7 is set, ticks are ignored and no field changes. Clearing the bit lets ticks advance the time again.
- R9: A write with wr_en high stores wr_data at wr_addr, where 0 is seconds, 1 minutes, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year and 7 control. The value reads back at rd_addr from the next cycle on.
- R10: A write in the same cycle as a tick takes priority. That tick is dropped and no field advances because of it.
- R11: Time advances by exactly one second per accepted tick and holds while tick is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for writes |
| wr_data | input | 8 | Byte to store |
| rd_addr | input | 3 | Register select for reads |
| rd_data | output | 8 | Selected register byte (combinational) |

## Verification
A full 86,400-tick run in 24-hour mode compares every second against an arithmetic model, covering all minute and hour carries and the midnight date carry. A second sweep places 23:59:59 on the last day of each month for every year from 00 to 99, which separates month-length and year-wrap errors from the leap rule. A further February 28 sweep over all years isolates the divisible-by-four test. A 24-step walk in 12-hour mode checks the 11-to-12 PM flip and the 12-to-01 wrap. Short directed cases cover reset, read-back, halting and write-over-tick priority.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam int HOUR_12H_BIT = 6;
    localparam int HOUR_PM_BIT  = 5;
    localparam int CTRL_HALT_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC  = 3'd0,
        REG_MIN  = 3'd1,
        REG_HOUR = 3'd2,
        REG_DOW  = 3'd3,
        REG_DOM  = 3'd4,
        REG_MON  = 3'd5,
        REG_YEAR = 3'd6,
        REG_CTRL = 3'd7
    } cal_reg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] dom;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] year;
    } cal_time_t;

    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_year(input logic [BYTE_W-1:0] y);
        logic [6:0] bin;
        bin = ({3'b000, y[7:4]} * 7'd10) + {3'b000, y[3:0]};
        return bin[1:0] == 2'b00;
    endfunction

    function automatic logic [BYTE_W-1:0] month_last_day(input logic [BYTE_W-1:0] mon,
                                                         input logic [BYTE_W-1:0] y);
        case (mon)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_field_counter.sv
module cal_field_counter
    import cal_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOW_VAL  = 8'h00,
    parameter logic [BYTE_W-1:0] HIGH_VAL = 8'h59,
    parameter logic [BYTE_W-1:0] INIT_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              inc,
    output logic [BYTE_W-1:0] value,
    output logic              carry
);

    logic at_top;
    assign at_top = (value == HIGH_VAL);
    assign carry  = inc && at_top;

    always_ff @(posedge clk) begin
        if (rst)
            value <= INIT_VAL;
        else if (load)
            value <= load_val;
        else if (inc)
            value <= at_top ? LOW_VAL : bcd_inc(value);
    end

    // R2 (also R5, R7 for the instances that hold weekday, month and year)
    assert_field_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && value == HIGH_VAL) |=> (value == LOW_VAL));

    assert_field_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load) |=> $stable(value));

endmodule

// File: rtl/cal_hour_counter.sv
module cal_hour_counter
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              inc,
    output logic [BYTE_W-1:0] value,
    output logic              carry
);

    logic              fmt12;
    logic              pm;
    logic [BYTE_W-1:0] hr;
    logic [BYTE_W-1:0] nxt;
    logic              wrap;

    assign fmt12 = value[HOUR_12H_BIT];
    assign pm    = value[HOUR_PM_BIT];
    assign hr    = fmt12 ? {3'b000, value[4:0]} : {2'b00, value[5:0]};

    always_comb begin
        wrap = 1'b0;
        nxt  = value;
        if (!fmt12) begin
            wrap = (hr == 8'h23);
            nxt  = wrap ? 8'h00 : bcd_inc(hr);
        end else if (hr == 8'h11) begin
            wrap = pm;
            nxt  = {1'b0, 1'b1, ~pm, 5'h12};
        end else if (hr == 8'h12) begin
            nxt  = {1'b0, 1'b1, pm, 5'h01};
        end else begin
            nxt  = {1'b0, 1'b1, pm, 5'(bcd_inc(hr))};
        end
    end

    assign carry = inc && wrap;

    always_ff @(posedge clk) begin
        if (rst)
            value <= 8'h00;
        else if (load)
            value <= load_val;
        else if (inc)
            value <= nxt;
    end

    assert_pm_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && fmt12 && value[4:0] == 5'h11) |=> (value[HOUR_PM_BIT] != $past(value[HOUR_PM_BIT])));

    assert_24h_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !fmt12 && value == 8'h23) |=> (value == 8'h00));

    assert_mode_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (value[HOUR_12H_BIT] == $past(value[HOUR_12H_BIT])));

endmodule

// File: rtl/cal_dom_counter.sv
module cal_dom_counter
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              inc,
    input  logic [BYTE_W-1:0] mon,
    input  logic [BYTE_W-1:0] year,
    output logic [BYTE_W-1:0] value,
    output logic              carry
);

    logic [BYTE_W-1:0] last_day;
    logic              at_last;

    assign last_day = month_last_day(mon, year);
    assign at_last  = (value == last_day);
    assign carry    = inc && at_last;

    always_ff @(posedge clk) begin
        if (rst)
            value <= 8'h01;
        else if (load)
            value <= load_val;
        else if (inc)
            value <= at_last ? 8'h01 : bcd_inc(value);
    end

    assert_dom_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && value == 8'h28 && mon == 8'h02 && !leap_year(year)) |=> (value == 8'h01));

    assert_dom_feb29_R6: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && value == 8'h28 && mon == 8'h02 && leap_year(year)) |=> (value == 8'h29));

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    cal_time_t         t;
    logic [BYTE_W-1:0] ctrl;
    logic              step;
    logic              c_sec, c_min, c_hour, c_dow, c_dom, c_mon, c_year;

    function automatic logic hit(input cal_reg_e r);
        return wr_en && (wr_addr == r);
    endfunction

    assign step = tick && !ctrl[CTRL_HALT_BIT] && !wr_en;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= 8'h80;
        else if (hit(REG_CTRL))
            ctrl <= wr_data;
    end

    cal_field_counter #(.LOW_VAL(8'h00), .HIGH_VAL(8'h59), .INIT_VAL(8'h00)) u_sec (
        .clk(clk), .rst(rst), .load(hit(REG_SEC)), .load_val(wr_data),
        .inc(step), .value(t.sec), .carry(c_sec));

    cal_field_counter #(.LOW_VAL(8'h00), .HIGH_VAL(8'h59), .INIT_VAL(8'h00)) u_min (
        .clk(clk), .rst(rst), .load(hit(REG_MIN)), .load_val(wr_data),
        .inc(c_sec), .value(t.min), .carry(c_min));

    cal_hour_counter u_hour (
        .clk(clk), .rst(rst), .load(hit(REG_HOUR)), .load_val(wr_data),
        .inc(c_min), .value(t.hour), .carry(c_hour));

    cal_field_counter #(.LOW_VAL(8'h01), .HIGH_VAL(8'h07), .INIT_VAL(8'h01)) u_dow (
        .clk(clk), .rst(rst), .load(hit(REG_DOW)), .load_val(wr_data),
        .inc(c_hour), .value(t.dow), .carry(c_dow));

    cal_dom_counter u_dom (
        .clk(clk), .rst(rst), .load(hit(REG_DOM)), .load_val(wr_data),
        .inc(c_hour), .mon(t.mon), .year(t.year), .value(t.dom), .carry(c_dom));

    cal_field_counter #(.LOW_VAL(8'h01), .HIGH_VAL(8'h12), .INIT_VAL(8'h01)) u_mon (
        .clk(clk), .rst(rst), .load(hit(REG_MON)), .load_val(wr_data),
        .inc(c_dom), .value(t.mon), .carry(c_mon));

    cal_field_counter #(.LOW_VAL(8'h00), .HIGH_VAL(8'h99), .INIT_VAL(8'h00)) u_year (
        .clk(clk), .rst(rst), .load(hit(REG_YEAR)), .load_val(wr_data),
        .inc(c_mon), .value(t.year), .carry(c_year));

    always_comb begin
        case (cal_reg_e'(rd_addr))
            REG_SEC:  rd_data = t.sec;
            REG_MIN:  rd_data = t.min;
            REG_HOUR: rd_data = t.hour;
            REG_DOW:  rd_data = t.dow;
            REG_DOM:  rd_data = t.dom;
            REG_MON:  rd_data = t.mon;
            REG_YEAR: rd_data = t.year;
            default:  rd_data = ctrl;
        endcase
    end

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl[CTRL_HALT_BIT] && !wr_en) |=> $stable(t));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != REG_SEC) |=> $stable(t.sec));

    assert_write_load_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_MIN) |=> (t.min == $past(wr_data)));

    assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(t));

    assert_year_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (c_year) |=> (t.year == 8'h00 && t.mon == 8'h01));

endmodule

// File: tb/bcd_calendar_core_test.sv
`timescale 1ns/100ps
module bcd_calendar_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcd_calendar_core uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [7:0] bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour12(input int h);
        int hh;
        hh = (h % 12 == 0) ? 12 : h % 12;
        return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(hh);
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_addr = 3'(a);
        #0.5;
        v = rd_data;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(2, h); wr(1, m); wr(0, s);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(0, v); chk(v, 8'h00, "R1 sec");
        rd(1, v); chk(v, 8'h00, "R1 min");
        rd(2, v); chk(v, 8'h00, "R1 hour");
        rd(3, v); chk(v, 8'h01, "R1 dow");
        rd(4, v); chk(v, 8'h01, "R1 dom");
        rd(5, v); chk(v, 8'h01, "R1 mon");
        rd(6, v); chk(v, 8'h00, "R1 year");
        rd(7, v); chk(v, 8'h80, "R1 ctrl");

        // R8 halted after reset: ticks ignored
        pulse(); pulse();
        rd(0, v); chk(v, 8'h00, "R8 halted sec");

        // R9 write and read back every address
        for (int a = 0; a < 7; a++) begin
            wr(a, 8'h05 + 8'(a));
            rd(a, v); chk(v, 8'h05 + 8'(a), "R9 readback");
        end
        wr(7, 8'h80); rd(7, v); chk(v, 8'h80, "R9 ctrl readback");

        // R2 R3 R11 full day in 24-hour mode
        set_time(8'h00, 8'h00, 8'h00);
        wr(3, 8'h01); wr(4, 8'h01); wr(5, 8'h01); wr(6, 8'h00);
        wr(7, 8'h00);
        for (int i = 1; i <= 86400; i++) begin
            logic [7:0] s, m, h;
            int tt;
            pulse();
            tt = i % 86400;
            rd(0, s); rd(1, m); rd(2, h);
            chk(s, bcd(tt % 60), "R2 R11 sec");
            if (m !== bcd((tt / 60) % 60)) chk(m, bcd((tt / 60) % 60), "R2 min");
            if (h !== bcd(tt / 3600)) chk(h, bcd(tt / 3600), "R3 hour");
        end
        rd(4, v); chk(v, 8'h02, "R3 day carry dom");
        rd(3, v); chk(v, 8'h02, "R5 dow after day");

        // R11 no tick: hold
        repeat (5) @(negedge clk);
        rd(0, v); chk(v, 8'h00, "R11 hold without tick");

        // R5 R6 R7 last day of every month of every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int d;
                int dw;
                d = mdays(m, y);
                dw = ((y * 12 + m) % 7) + 1;
                wr(6, bcd(y)); wr(5, bcd(m)); wr(4, bcd(d)); wr(3, bcd(dw));
                set_time(8'h23, 8'h59, 8'h59);
                pulse();
                rd(4, v); chk(v, 8'h01, "R6 dom wrap");
                rd(5, v); chk(v, bcd(m == 12 ? 1 : m + 1), "R7 month step");
                rd(6, v); chk(v, bcd(m == 12 ? (y + 1) % 100 : y), "R7 year step");
                rd(3, v); chk(v, bcd(dw == 7 ? 1 : dw + 1), "R5 dow step");
                rd(2, v); chk(v, 8'h00, "R3 hour wrap");
            end
        end

        // R6 February 28 in every year
        for (int y = 0; y < 100; y++) begin
            wr(6, bcd(y)); wr(5, 8'h02); wr(4, 8'h28);
            set_time(8'h23, 8'h59, 8'h59);
            pulse();
            rd(4, v); chk(v, (y % 4 == 0) ? 8'h29 : 8'h01, "R6 feb28 step");
            rd(5, v); chk(v, (y % 4 == 0) ? 8'h02 : 8'h03, "R6 feb28 month");
        end

        // R4 12-hour walk through a whole day
        wr(4, 8'h10); wr(5, 8'h05); wr(6, 8'h21);
        wr(2, hour12(0));
        for (int h = 0; h < 24; h++) begin
            wr(1, 8'h59); wr(0, 8'h59);
            pulse();
            rd(2, v); chk(v, hour12((h + 1) % 24), "R4 12h hour");
            if (h < 23) begin
                rd(4, v); chk(v, 8'h10, "R4 no day carry");
            end
        end
        rd(4, v); chk(v, 8'h11, "R4 day carry at 12 AM");

        // R10 write in the same cycle as a tick
        set_time(8'h05, 8'h10, 8'h10);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
        @(posedge clk);
        #1 tick = 1'b0; wr_en = 1'b0;
        rd(0, v); chk(v, 8'h10, "R10 sec not advanced");
        rd(1, v); chk(v, 8'h30, "R10 min written");

        // R8 halt then resume
        wr(7, 8'h80);
        pulse(); pulse(); pulse();
        rd(0, v); chk(v, 8'h10, "R8 frozen");
        wr(7, 8'h00);
        pulse();
        rd(0, v); chk(v, 8'h11, "R8 resumed");

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule